// File: doc/BRIEF.md
# Scaler Tap Count Selector

This block decides how many filter taps each of the four scaler directions uses: horizontal luma, vertical luma, horizontal chroma and vertical chroma. A request carries the four scale ratios, the four tap counts asked for, and the limits that can make the request unusable. The limits are a half-float source flag, a fixed-point-only scaler flag, the viewport width, the active width and an optional cap on the source width for downscaling. An override forces real filtering even when a ratio is 1.0.

A one-cycle `start` pulse hands a request in. One clock later `done` pulses. If the request is admitted, the tap counts and the adjusted ratios are updated at that edge. If it is refused, `reject` pulses with `done` and every result keeps the value it had. Results do not change between requests.

Ratios are unsigned fixed point with 3 integer and 32 fractional bits, so 1.0 is 0x1_0000_0000 and 4.0 is 0x4_0000_0000.

Top module: `scaler_tap_selector`

## Requirements
- R1: `done` is high in exactly the cycle after the cycle in which `start` was sampled high, and is low at all other times.
- R2: A luma tap request of 0, horizontal or vertical, resolves to 4 taps. Any non-zero luma request is passed through unchanged, unless R6 applies.
- R3: A chroma tap request of 0, horizontal or vertical, resolves to 2 taps.
- R4: A horizontal chroma request that is odd and larger than 1 resolves to that value minus one. A request of 1 or an even request is kept. The vertical chroma request gets no parity change.
- R5: A ratio equal to exactly 4.0 (0x4_0000_0000) appears on its adjusted-ratio output as 0x3_FFFF_FFFF. Every other ratio is output unchanged.
- R6: When `force_scale` is 0, a direction whose ratio equals 1.0 after truncation to 19 fractional bits (ratio >> 13 == 1 << 19) resolves to 1 tap. This overrides R2 to R4. When `force_scale` is 1, this rule is skipped.
- R7: A request is refused when `src_is_fp16` and `fixed_point_only` are both 1 and neither luma ratio is exactly 1.0. If either luma ratio is exactly 1.0, this rule does not refuse it.
- R8: A request is refused when `view_width` > `active_width`, `max_src_width` is non-zero, and `view_width` > `max_src_width`.
- R9: On a refused request, `reject` is high together with `done`, and all tap and adjusted-ratio outputs keep their previous values. `reject` is low at every other time.
- R10: After reset, `done` and `reject` are 0 and all tap and adjusted-ratio outputs are 0.
- R11: Tap and adjusted-ratio outputs change only at the edge that follows a sampled `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| ratio_lh | input | 35 | Horizontal luma ratio, U3.32 |
| ratio_lv | input | 35 | Vertical luma ratio, U3.32 |
| ratio_ch | input | 35 | Horizontal chroma ratio, U3.32 |
| ratio_cv | input | 35 | Vertical chroma ratio, U3.32 |
| req_lh | input | 4 | Requested horizontal luma taps, 0 = default |
| req_lv | input | 4 | Requested vertical luma taps, 0 = default |
| req_ch | input | 4 | Requested horizontal chroma taps, 0 = default |
| req_cv | input | 4 | Requested vertical chroma taps, 0 = default |
| src_is_fp16 | input | 1 | Source pixels are half-float |
| fixed_point_only | input | 1 | Scaler datapath is fixed-point only |
| view_width | input | 14 | Viewport width in pixels |
| active_width | input | 14 | Active output width in pixels |
| max_src_width | input | 14 | Downscale source width cap, 0 = none |
| force_scale | input | 1 | Disable the identity-ratio bypass |
| done | output | 1 | Result strobe |
| reject | output | 1 | Request refused, pulses with done |
| tap_lh | output | 4 | Horizontal luma taps |
| tap_lv | output | 4 | Vertical luma taps |
| tap_ch | output | 4 | Horizontal chroma taps |
| tap_cv | output | 4 | Vertical chroma taps |
| adj_lh | output | 35 | Adjusted horizontal luma ratio |
| adj_lv | output | 35 | Adjusted vertical luma ratio |
| adj_ch | output | 35 | Adjusted horizontal chroma ratio |
| adj_cv | output | 35 | Adjusted vertical chroma ratio |

## Verification
Refusal and tap resolution act in the same cycle. A refused request still computes fresh taps, and the refusal must discard them. The bench sends refused requests whose tap fields would produce different results (zero, odd, and 4.0 ratios), and checks that every output still equals the last admitted request. The identity bypass can also coincide with the default and parity rules on one direction: a zero or odd request paired with a 1.0 ratio must resolve to 1 tap, and resolves through the other rule when the override is set.

// File: rtl/tap_sel_pkg.sv
package tap_sel_pkg;

    parameter int INT_W       = 3;
    parameter int FRAC_W      = 32;
    parameter int RATIO_W     = INT_W + FRAC_W;
    parameter int TAP_W       = 4;
    parameter int WID_W       = 14;
    parameter int ID_FRAC     = 19;
    parameter int LUMA_DFLT   = 4;
    parameter int CHROMA_DFLT = 2;
    parameter int N_DIR       = 4;

    localparam int ID_SHIFT = FRAC_W - ID_FRAC;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [TAP_W-1:0]   tap_t;
    typedef logic [WID_W-1:0]   width_t;

    typedef enum logic [1:0] {
        DIR_LUMA_H   = 2'd0,
        DIR_LUMA_V   = 2'd1,
        DIR_CHROMA_H = 2'd2,
        DIR_CHROMA_V = 2'd3
    } dir_e;

    typedef struct packed {
        ratio_t ratio;
        tap_t   req;
    } dir_req_t;

    typedef struct packed {
        ratio_t ratio;
        tap_t   taps;
    } dir_res_t;

    function automatic ratio_t ratio_unity();
        return ratio_t'(1) << FRAC_W;
    endfunction

    function automatic ratio_t ratio_four();
        return ratio_t'(4) << FRAC_W;
    endfunction

    function automatic logic near_unity(input ratio_t r);
        return (r >> ID_SHIFT) == (ratio_t'(1) << ID_FRAC);
    endfunction

endpackage

// File: rtl/tap_ratio_clamp.sv
module tap_ratio_clamp
    import tap_sel_pkg::*;
(
    input  ratio_t raw,
    output ratio_t adj
);
    always_comb begin
        if (raw == ratio_four())
            adj = raw - ratio_t'(1);
        else
            adj = raw;
    end
endmodule

// File: rtl/tap_count_resolve.sv
module tap_count_resolve
    import tap_sel_pkg::*;
#(
    parameter int DFLT_TAPS = 4,
    parameter bit EVEN_ONLY = 1'b0
) (
    input  tap_t   req,
    input  ratio_t ratio,
    input  logic   force_scale,
    output tap_t   taps
);
    localparam tap_t DFLT = tap_t'(DFLT_TAPS);

    tap_t base;

    generate
        if (EVEN_ONLY) begin : g_even
            always_comb begin
                if (req == '0)
                    base = DFLT;
                else if (req[0] && req != tap_t'(1))
                    base = req - tap_t'(1);
                else
                    base = req;
            end
        end else begin : g_plain
            always_comb begin
                base = (req == '0) ? DFLT : req;
            end
        end
    endgenerate

    always_comb begin
        if (!force_scale && near_unity(ratio))
            taps = tap_t'(1);
        else
            taps = base;
    end
endmodule

// File: rtl/tap_request_gate.sv
module tap_request_gate
    import tap_sel_pkg::*;
(
    input  ratio_t luma_h,
    input  ratio_t luma_v,
    input  logic   src_is_fp16,
    input  logic   fixed_point_only,
    input  width_t view_width,
    input  width_t active_width,
    input  width_t max_src_width,
    output logic   admit
);
    logic fp_block;
    logic width_block;

    always_comb begin
        fp_block    = src_is_fp16 && fixed_point_only &&
                      (luma_h != ratio_unity()) && (luma_v != ratio_unity());
        width_block = (view_width > active_width) && (max_src_width != '0) &&
                      (view_width > max_src_width);
        admit       = !(fp_block || width_block);
    end
endmodule

// File: rtl/scaler_tap_selector.sv
module scaler_tap_selector
    import tap_sel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [RATIO_W-1:0]  ratio_lh,
    input  logic [RATIO_W-1:0]  ratio_lv,
    input  logic [RATIO_W-1:0]  ratio_ch,
    input  logic [RATIO_W-1:0]  ratio_cv,
    input  logic [TAP_W-1:0]    req_lh,
    input  logic [TAP_W-1:0]    req_lv,
    input  logic [TAP_W-1:0]    req_ch,
    input  logic [TAP_W-1:0]    req_cv,
    input  logic                src_is_fp16,
    input  logic                fixed_point_only,
    input  logic [WID_W-1:0]    view_width,
    input  logic [WID_W-1:0]    active_width,
    input  logic [WID_W-1:0]    max_src_width,
    input  logic                force_scale,
    output logic                done,
    output logic                reject,
    output logic [TAP_W-1:0]    tap_lh,
    output logic [TAP_W-1:0]    tap_lv,
    output logic [TAP_W-1:0]    tap_ch,
    output logic [TAP_W-1:0]    tap_cv,
    output logic [RATIO_W-1:0]  adj_lh,
    output logic [RATIO_W-1:0]  adj_lv,
    output logic [RATIO_W-1:0]  adj_ch,
    output logic [RATIO_W-1:0]  adj_cv
);
    dir_req_t req_a  [N_DIR];
    dir_res_t next_a [N_DIR];
    dir_res_t res_q  [N_DIR];
    logic     admit;
    logic     done_q;
    logic     reject_q;

    assign req_a[DIR_LUMA_H]   = '{ratio: ratio_lh, req: req_lh};
    assign req_a[DIR_LUMA_V]   = '{ratio: ratio_lv, req: req_lv};
    assign req_a[DIR_CHROMA_H] = '{ratio: ratio_ch, req: req_ch};
    assign req_a[DIR_CHROMA_V] = '{ratio: ratio_cv, req: req_cv};

    generate
        for (genvar g = 0; g < N_DIR; g++) begin : g_dir
            localparam int DF = (g < 2) ? LUMA_DFLT : CHROMA_DFLT;
            localparam bit EV = (g == int'(DIR_CHROMA_H));

            ratio_t clamped;

            tap_ratio_clamp u_clamp (
                .raw (req_a[g].ratio),
                .adj (clamped)
            );

            tap_count_resolve #(
                .DFLT_TAPS (DF),
                .EVEN_ONLY (EV)
            ) u_resolve (
                .req         (req_a[g].req),
                .ratio       (clamped),
                .force_scale (force_scale),
                .taps        (next_a[g].taps)
            );

            assign next_a[g].ratio = clamped;
        end
    endgenerate

    tap_request_gate u_gate (
        .luma_h           (ratio_lh),
        .luma_v           (ratio_lv),
        .src_is_fp16      (src_is_fp16),
        .fixed_point_only (fixed_point_only),
        .view_width       (view_width),
        .active_width     (active_width),
        .max_src_width    (max_src_width),
        .admit            (admit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            reject_q <= 1'b0;
            for (int i = 0; i < N_DIR; i++)
                res_q[i] <= '0;
        end else begin
            done_q   <= start;
            reject_q <= start && !admit;
            if (start && admit) begin
                for (int i = 0; i < N_DIR; i++)
                    res_q[i] <= next_a[i];
            end
        end
    end

    assign done   = done_q;
    assign reject = reject_q;
    assign tap_lh = res_q[DIR_LUMA_H].taps;
    assign tap_lv = res_q[DIR_LUMA_V].taps;
    assign tap_ch = res_q[DIR_CHROMA_H].taps;
    assign tap_cv = res_q[DIR_CHROMA_V].taps;
    assign adj_lh = res_q[DIR_LUMA_H].ratio;
    assign adj_lv = res_q[DIR_LUMA_V].ratio;
    assign adj_ch = res_q[DIR_CHROMA_H].ratio;
    assign adj_cv = res_q[DIR_CHROMA_V].ratio;
endmodule

// File: rtl/tap_sel_checker.sv
module tap_sel_checker
    import tap_sel_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done,
    input logic               reject,
    input logic [TAP_W-1:0]   tap_lh,
    input logic [TAP_W-1:0]   tap_lv,
    input logic [TAP_W-1:0]   tap_ch,
    input logic [TAP_W-1:0]   tap_cv,
    input logic [RATIO_W-1:0] adj_lh,
    input logic [RATIO_W-1:0] adj_lv,
    input logic [RATIO_W-1:0] adj_ch,
    input logic [RATIO_W-1:0] adj_cv
);
    p_done_follows_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    p_done_only_after_r1: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    p_reject_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        reject |-> done);

    p_reject_holds_r9: assert property (@(posedge clk) disable iff (rst)
        reject |-> ($stable(tap_lh) && $stable(tap_lv) && $stable(tap_ch) &&
                    $stable(tap_cv) && $stable(adj_lh) && $stable(adj_cv)));

    p_quiet_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(tap_lh) && $stable(tap_lv) && $stable(tap_ch) &&
                   $stable(tap_cv) && $stable(adj_lh) && $stable(adj_lv) &&
                   $stable(adj_ch) && $stable(adj_cv)));

    p_chroma_parity_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !reject) |-> (tap_ch == TAP_W'(1) || !tap_ch[0]));

    p_no_four_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !reject) |-> (adj_lh != ratio_four() && adj_lv != ratio_four() &&
                               adj_ch != ratio_four() && adj_cv != ratio_four()));
endmodule

bind scaler_tap_selector tap_sel_checker u_chk (.*);

// File: tb/scaler_tap_selector_test.sv
`timescale 1ns/1ps
module scaler_tap_selector_test;
    import tap_sel_pkg::*;

    localparam ratio_t ONE     = ratio_t'(64'h1_0000_0000);
    localparam ratio_t FOUR    = ratio_t'(64'h4_0000_0000);
    localparam ratio_t ONEHALF = ratio_t'(64'h1_8000_0000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    ratio_t r_lh = '0, r_lv = '0, r_ch = '0, r_cv = '0;
    tap_t q_lh = '0, q_lv = '0, q_ch = '0, q_cv = '0;
    logic fp16 = 1'b0, fixo = 1'b0, fscale = 1'b0;
    width_t vw = '0, aw = '0, mw = '0;
    logic done, reject;
    tap_t t_lh, t_lv, t_ch, t_cv;
    ratio_t a_lh, a_lv, a_ch, a_cv;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int last_tap [4];
    ratio_t last_ratio [4];

    always #2.5 clk = ~clk;

    scaler_tap_selector uut (
        .clk(clk), .rst(rst), .start(start),
        .ratio_lh(r_lh), .ratio_lv(r_lv), .ratio_ch(r_ch), .ratio_cv(r_cv),
        .req_lh(q_lh), .req_lv(q_lv), .req_ch(q_ch), .req_cv(q_cv),
        .src_is_fp16(fp16), .fixed_point_only(fixo),
        .view_width(vw), .active_width(aw), .max_src_width(mw),
        .force_scale(fscale), .done(done), .reject(reject),
        .tap_lh(t_lh), .tap_lv(t_lv), .tap_ch(t_ch), .tap_cv(t_cv),
        .adj_lh(a_lh), .adj_lv(a_lv), .adj_ch(a_ch), .adj_cv(a_cv)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_tap(input int req, input int d, input ratio_t r, input bit fs);
        int t;
        t = (req == 0) ? ((d < 2) ? 4 : 2) : req;
        if (d == 2 && req > 1 && (req % 2) == 1) t = req - 1;
        if (!fs && (r >> 13) == (ratio_t'(1) << 19)) t = 1;
        return t;
    endfunction

    function automatic string tap_tag(input int req, input int d, input ratio_t r, input bit fs);
        if (!fs && (r >> 13) == (ratio_t'(1) << 19)) return "R6";
        if (req == 0) return (d < 2) ? "R2" : "R3";
        if (d == 2) return "R4";
        return "R2";
    endfunction

    task automatic compare_outputs(input string tag_override);
        tap_t   at [4];
        ratio_t ar [4];
        at[0] = t_lh; at[1] = t_lv; at[2] = t_ch; at[3] = t_cv;
        ar[0] = a_lh; ar[1] = a_lv; ar[2] = a_ch; ar[3] = a_cv;
        for (int d = 0; d < 4; d++) begin
            chk(int'(at[d]) == last_tap[d], tag_override, at[d], last_tap[d]);
            chk(ar[d] == last_ratio[d], (tag_override == "") ? "R5" : tag_override,
                ar[d], last_ratio[d]);
        end
    endtask

    task automatic run(input ratio_t rlh, rlv, rch, rcv,
                       input int qlh, qlv, qch, qcv,
                       input bit f16, fx, input int w_v, w_a, w_m, input bit fs,
                       input string rej_tag);
        ratio_t rr [4];
        int     qq [4];
        bit     exp_rej;
        tap_t   at [4];
        rr[0] = rlh; rr[1] = rlv; rr[2] = rch; rr[3] = rcv;
        qq[0] = qlh; qq[1] = qlv; qq[2] = qch; qq[3] = qcv;
        @(negedge clk);
        r_lh = rlh; r_lv = rlv; r_ch = rch; r_cv = rcv;
        q_lh = tap_t'(qlh); q_lv = tap_t'(qlv); q_ch = tap_t'(qch); q_cv = tap_t'(qcv);
        fp16 = f16; fixo = fx; vw = width_t'(w_v); aw = width_t'(w_a); mw = width_t'(w_m);
        fscale = fs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_rej = (f16 && fx && rlh != ONE && rlv != ONE) ||
                  (w_v > w_a && w_m != 0 && w_v > w_m);
        chk(done == 1'b1, "R1", done, 1);
        chk(reject == exp_rej, rej_tag, reject, exp_rej);
        if (exp_rej) begin
            compare_outputs("R9");
        end else begin
            at[0] = t_lh; at[1] = t_lv; at[2] = t_ch; at[3] = t_cv;
            for (int d = 0; d < 4; d++) begin
                last_tap[d]   = exp_tap(qq[d], d, rr[d], fs);
                last_ratio[d] = (rr[d] == FOUR) ? FOUR - ratio_t'(1) : rr[d];
                chk(int'(at[d]) == last_tap[d], tap_tag(qq[d], d, rr[d], fs),
                    at[d], last_tap[d]);
            end
            compare_outputs("");
        end
        r_lh = ONEHALF; q_lh = tap_t'(0); q_ch = tap_t'(3);
        @(negedge clk);
        chk(done == 1'b0, "R1", done, 0);
        chk(reject == 1'b0, "R9", reject, 0);
        compare_outputs("R11");
    endtask

    initial begin
        for (int d = 0; d < 4; d++) begin
            last_tap[d] = 0;
            last_ratio[d] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R10", done, 0);
        chk(reject == 1'b0, "R10", reject, 0);
        compare_outputs("R10");

        for (int q = 0; q < 16; q++)
            run(ONEHALF, ONEHALF, ONEHALF, ONEHALF, q, (q + 5) % 16, q, (q + 9) % 16,
                0, 0, 100, 100, 0, 0, "R7");

        for (int k = 0; k < 6; k++) begin
            ratio_t r;
            case (k)
                0: r = ONE;
                1: r = ONE + ratio_t'(13'h1FFF);
                2: r = ONE + ratio_t'(14'h2000);
                3: r = ONE - ratio_t'(1);
                4: r = FOUR;
                default: r = FOUR - ratio_t'(1);
            endcase
            for (int fs = 0; fs < 2; fs++) begin
                run(r, ONEHALF, ONEHALF, ONEHALF, 0, 3, 5, 0, 0, 0, 10, 10, 0, fs[0], "R5");
                run(ONEHALF, r, r, ONEHALF, 6, 0, 0, 7, 0, 0, 10, 10, 0, fs[0], "R6");
                run(ONEHALF, ONEHALF, ONEHALF, r, 7, 8, 1, 0, 0, 0, 10, 10, 0, fs[0], "R6");
                run(r, r, r, r, 0, 0, 7, 0, 0, 0, 10, 10, 0, fs[0], "R6");
            end
        end

        run(ONEHALF, ONEHALF, ONEHALF, ONEHALF, 3, 3, 3, 3, 0, 0, 10, 10, 0, 0, "R7");
        for (int m = 0; m < 8; m++)
            run(FOUR, FOUR, ONEHALF, ONE, 0, 0, 5, 0, m[0], m[1], 10, 10, 0, m[2], "R7");
        run(ONE, FOUR, ONEHALF, ONEHALF, 0, 0, 9, 0, 1, 1, 10, 10, 0, 0, "R7");
        run(FOUR, ONE, ONEHALF, ONEHALF, 0, 0, 9, 0, 1, 1, 10, 10, 0, 0, "R7");
        run(ONEHALF, ONEHALF, ONEHALF, ONEHALF, 2, 2, 2, 2, 0, 0, 10, 10, 0, 0, "R8");

        for (int v = 8; v <= 12; v++)
            for (int a = 8; a <= 12; a += 2)
                for (int mx = 0; mx <= 11; mx += 3)
                    run(FOUR, ONEHALF, ONE, ONEHALF, 0, 5, 3, 0, 0, 0, v, a, mx, 0, "R8");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule